// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Clock-Domain Handshake

This block carries single transfer events from one clock domain to another, unrelated one. A sender machine in the source clock takes a one-cycle start pulse from local logic. It raises a request level and keeps it up until the acknowledge, resynchronized into its own clock, comes back high. It then lowers the request and waits for the acknowledge to fall. When the acknowledge is low, it issues a one-cycle done pulse and returns to idle. A receiver machine in the destination clock sees the resynchronized request and raises acknowledge. It strobes its local logic for exactly one cycle. It then holds acknowledge until it sees the request low again.

Each level that crosses a domain passes through a chain of two flip-flops clocked by the destination clock before a state machine uses it. Both machines are Moore machines with active-low asynchronous reset. Their outputs are single state bits, so nothing combinational crosses the boundary. Idle is the all-zero code and each active state is a one-hot bit on top of bit 0, so idle is simply bit 0 low. Any code outside the legal set falls back to idle on the next clock.

Top module: `hs_cdc_handshake`

## Requirements
- R1: A start pulse sampled while the sender is idle raises `req_o` and `busy_o` on the next `clk_a` edge. `req_o` then stays high until the sender has seen the synchronized acknowledge high.
- R2: `req_o` falls only after the sender has seen the synchronized acknowledge high. The wire order is always req rise, ack rise, req fall, ack fall.
- R3: `ack_o` rises only after the receiver has seen the synchronized request high. It falls only after the receiver has seen the synchronized request low.
- R4: After dropping the request, the sender waits for the synchronized acknowledge to be low. It then raises `done_o` for one `clk_a` cycle while `ack_o` is low, and `busy_o` is low on the following cycle.
- R5: Each accepted start produces exactly one `strobe_o` pulse, one `clk_b` cycle wide, in the cycle where `ack_o` rises.
- R6: A start sampled while `busy_o` is high has no effect on requests, strobes or state. This includes the done cycle.
- R7: Every crossing level passes two destination-clock flip-flops. `ack_o` therefore rises more than two `clk_b` periods after `req_o` rises, and `req_o` falls more than two `clk_a` periods after `ack_o` rises.
- R8: While its active-low reset is asserted, each machine sits in the idle code 4'b0000 with all of its outputs low.
- R9: The state codes are idle 4'b0000; sender request 4'b0011, drain 4'b0101 and done 4'b1001; receiver new 4'b0011 and hold 4'b0101. Output mapping: `req_o` = bit 1, `busy_o` = bit 0, `done_o` = bit 3, `ack_o` = bit 0, `strobe_o` = bit 1. Any other code returns to idle on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Sender clock |
| rst_a_n | input | 1 | Sender active-low asynchronous reset |
| start_i | input | 1 | Start pulse from sender-side logic |
| busy_o | output | 1 | Sender is in a transfer (start ignored) |
| done_o | output | 1 | One-cycle pulse when a transfer completes |
| req_o | output | 1 | Request level crossing to clk_b |
| clk_b | input | 1 | Receiver clock |
| rst_b_n | input | 1 | Receiver active-low asynchronous reset |
| strobe_o | output | 1 | One-cycle pulse per received request |
| ack_o | output | 1 | Acknowledge level crossing to clk_a |

## Verification
An isolated start checks the basic interlock order and the two-flop latency in each direction. A run of back-to-back starts, issued as soon as busy drops while the receive clock drifts a few percent around the send clock, shows that no event is lost or doubled as the phase relation slides. Starts issued mid-transfer and in the done cycle tell an ignored start apart from one that leaks into an extra strobe. An injected illegal sender code shows recovery to idle rather than lock-up.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef logic [3:0] code_t;

    // Idle is all zero; active codes are one-hot above bit 0 with bit 0 set.
    localparam code_t ST_IDLE  = 4'b0000;
    localparam code_t TX_REQ   = 4'b0011;
    localparam code_t TX_DRAIN = 4'b0101;
    localparam code_t TX_DONE  = 4'b1001;
    localparam code_t RX_NEW   = 4'b0011;
    localparam code_t RX_HOLD  = 4'b0101;

    localparam int SYNC_DEPTH_MIN = 2;

    function automatic logic code_is_idle(code_t c);
        return !c[0];
    endfunction

    function automatic logic tx_code_legal(code_t c);
        return (c == ST_IDLE) || (c == TX_REQ) || (c == TX_DRAIN) || (c == TX_DONE);
    endfunction

    function automatic logic rx_code_legal(code_t c);
        return (c == ST_IDLE) || (c == RX_NEW) || (c == RX_HOLD);
    endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int STAGES = hs_pkg::SYNC_DEPTH_MIN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[LAST-1:0], d};
            end
        end
    endgenerate

    assign q = chain_q[LAST];

endmodule

// File: rtl/hs_sender.sv
module hs_sender
    import hs_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_DEPTH_MIN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ack_async,
    output logic req,
    output logic busy,
    output logic done
);
    code_t state_q, state_d;
    logic  ack_s;

    hs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_async),
        .q     (ack_s)
    );

    always_comb begin
        state_d = ST_IDLE;
        case (state_q)
            ST_IDLE:  state_d = start ? TX_REQ : ST_IDLE;
            TX_REQ:   state_d = ack_s ? TX_DRAIN : TX_REQ;
            TX_DRAIN: state_d = ack_s ? TX_DRAIN : TX_DONE;
            TX_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign req  = state_q[1];
    assign busy = state_q[0];
    assign done = state_q[3];

    // R1
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack_s) |=> req);
    // R2
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> $past(ack_s));
    // R4
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> (!$past(ack_s) && $past(code_is_idle(state_q))));
    // R4
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R9
    tx_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_code_legal(state_q) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/hs_receiver.sv
module hs_receiver
    import hs_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_DEPTH_MIN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    output logic ack,
    output logic strobe
);
    code_t state_q, state_d;
    logic  req_s;

    hs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_async),
        .q     (req_s)
    );

    always_comb begin
        state_d = ST_IDLE;
        case (state_q)
            ST_IDLE: state_d = req_s ? RX_NEW : ST_IDLE;
            RX_NEW:  state_d = RX_HOLD;
            RX_HOLD: state_d = req_s ? RX_HOLD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign ack    = state_q[0];
    assign strobe = state_q[1];

    // R3
    ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(req_s));
    // R3
    ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack) |-> !$past(req_s));
    // R5
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
    // R5
    strobe_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> strobe);
    // R9
    rx_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_code_legal(state_q) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/hs_cdc_handshake.sv
module hs_cdc_handshake
    import hs_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_DEPTH_MIN
) (
    input  logic clk_a,
    input  logic rst_a_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o,
    output logic req_o,
    input  logic clk_b,
    input  logic rst_b_n,
    output logic strobe_o,
    output logic ack_o
);
    logic req_w;
    logic ack_w;

    hs_sender #(.SYNC_STAGES(SYNC_STAGES)) u_tx (
        .clk       (clk_a),
        .rst_n     (rst_a_n),
        .start     (start_i),
        .ack_async (ack_w),
        .req       (req_w),
        .busy      (busy_o),
        .done      (done_o)
    );

    hs_receiver #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk       (clk_b),
        .rst_n     (rst_b_n),
        .req_async (req_w),
        .ack       (ack_w),
        .strobe    (strobe_o)
    );

    assign req_o = req_w;
    assign ack_o = ack_w;

endmodule

// File: tb/hs_cdc_handshake_tb.sv
`timescale 1ns/1ps
module hs_cdc_handshake_tb;

    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    logic rst_a_n = 1'b0;
    logic rst_b_n = 1'b0;
    logic start_i = 1'b0;
    logic busy_o, done_o, req_o, strobe_o, ack_o;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    int accepted = 0;
    int rx_count = 0;
    int phase = 0;
    bit armed = 1'b0;
    bit prev_strobe = 1'b0;
    realtime t_req_r = 0.0;
    realtime t_ack_r = 0.0;

    hs_cdc_handshake u_dut (
        .clk_a    (clk_a),
        .rst_a_n  (rst_a_n),
        .start_i  (start_i),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .req_o    (req_o),
        .clk_b    (clk_b),
        .rst_b_n  (rst_b_n),
        .strobe_o (strobe_o),
        .ack_o    (ack_o)
    );

    always #4 clk_a = ~clk_a;

    initial begin : clk_b_gen
        real pb;
        real step;
        pb = 8.3;
        step = 0.013;
        forever begin
            #(pb / 2.0) clk_b = 1'b1;
            #(pb / 2.0) clk_b = 1'b0;
            pb = pb + step;
            if (pb > 8.4 || pb < 7.8) step = -step;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Interlock order and synchronizer latency, watched at the ports.
    always @(posedge req_o) if (armed) begin
        chk(phase == 0, "R1 order req rise", phase, 0);
        phase = 1;
        t_req_r = $realtime;
    end
    always @(posedge ack_o) if (armed) begin
        chk(phase == 1, "R3 order ack rise", phase, 1);
        chk(($realtime - t_req_r) > 15.5, "R7 req->ack latency ps",
            int'(($realtime - t_req_r) * 1000.0), 15500);
        phase = 2;
        t_ack_r = $realtime;
    end
    always @(negedge req_o) if (armed) begin
        chk(phase == 2, "R2 order req fall", phase, 2);
        chk(($realtime - t_ack_r) > 15.5, "R7 ack->req latency ps",
            int'(($realtime - t_ack_r) * 1000.0), 15500);
        phase = 3;
    end
    always @(negedge ack_o) if (armed) begin
        chk(phase == 3, "R3 order ack fall", phase, 3);
        phase = 0;
    end

    // Scoreboard monitor: each strobe pops one expected transfer.
    always @(negedge clk_b) if (armed) begin
        if (strobe_o) begin
            chk(!prev_strobe, "R5 strobe width", 2, 1);
            chk(ack_o, "R5 strobe with ack", int'(ack_o), 1);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected strobe", rx_count + 1, accepted);
            end else begin
                int id;
                id = exp_q.pop_front();
                chk(id == rx_count, "R5 strobe order", id, rx_count);
            end
            rx_count++;
        end
        prev_strobe = strobe_o;
    end

    // Driver: model accepts the start only when busy is low.
    task automatic send(output bit acc);
        @(negedge clk_a);
        acc = !busy_o;
        start_i = 1'b1;
        if (acc) begin
            exp_q.push_back(accepted);
            accepted++;
        end
        @(negedge clk_a);
        start_i = 1'b0;
        if (acc) begin
            chk(req_o == 1'b1, "R1 req after start", int'(req_o), 1);
            chk(busy_o == 1'b1, "R1 busy after start", int'(busy_o), 1);
        end
    endtask

    task automatic wait_idle();
        bit seen_done;
        bit ok;
        seen_done = 1'b0;
        ok = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk_a);
            if (done_o) begin
                chk(ack_o == 1'b0, "R4 ack low at done", int'(ack_o), 0);
                chk(req_o == 1'b0, "R4 req low at done", int'(req_o), 0);
                seen_done = 1'b1;
            end
            if (!busy_o) begin
                ok = 1'b1;
                break;
            end
        end
        chk(ok, "R4 return to idle", int'(ok), 1);
        chk(seen_done, "R4 done pulse seen", int'(seen_done), 1);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk_a);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk_a);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin : main
        bit acc;
        // R8: reset state
        #3;
        chk({busy_o, done_o, req_o, strobe_o, ack_o} == 5'b0, "R8 outputs in reset",
            int'({busy_o, done_o, req_o, strobe_o, ack_o}), 0);
        #27 rst_a_n = 1'b1;
        #5  rst_b_n = 1'b1;
        armed = 1'b1;
        settle(4);
        chk({busy_o, done_o, req_o, strobe_o, ack_o} == 5'b0, "R8 idle after reset",
            int'({busy_o, done_o, req_o, strobe_o, ack_o}), 0);

        // Single isolated transfer
        send(acc);
        chk(acc, "R1 start accepted", int'(acc), 1);
        wait_idle();
        settle(10);
        chk(rx_count == 1, "R5 one strobe for one start", rx_count, 1);

        // R6: start while busy is ignored
        send(acc);
        settle(3);
        send(acc);
        chk(!acc, "R6 model sees busy", int'(acc), 0);
        chk(busy_o == 1'b1, "R6 still busy", int'(busy_o), 1);
        wait_idle();
        settle(20);
        chk(rx_count == 2, "R6 no strobe from ignored start", rx_count, 2);
        chk(req_o == 1'b0, "R6 no request from ignored start", int'(req_o), 0);

        // R6: start during the done cycle
        send(acc);
        begin
            bit hit;
            hit = 1'b0;
            for (int i = 0; i < 400; i++) begin
                @(negedge clk_a);
                if (done_o) begin
                    hit = 1'b1;
                    break;
                end
            end
            chk(hit, "R4 done reached", int'(hit), 1);
            start_i = 1'b1;
            @(negedge clk_a);
            start_i = 1'b0;
            chk(busy_o == 1'b0, "R6 start in done cycle ignored", int'(busy_o), 0);
            chk(done_o == 1'b0, "R4 done one cycle", int'(done_o), 0);
        end
        settle(20);
        chk(req_o == 1'b0, "R6 no request after done-cycle start", int'(req_o), 0);
        chk(rx_count == 3, "R6 strobe count after done-cycle start", rx_count, 3);

        // Back-to-back transfers while clk_b drifts
        for (int k = 0; k < 40; k++) begin
            send(acc);
            chk(acc, "R1 back-to-back accepted", int'(acc), 1);
            wait_idle();
        end
        settle(20);
        chk(rx_count == accepted, "R5 strobes equal starts", rx_count, accepted);
        chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);

        // R9: illegal sender code recovers to idle
        @(negedge clk_a);
        force u_dut.u_tx.state_q = 4'b0001;
        #1 release u_dut.u_tx.state_q;
        chk(busy_o == 1'b1, "R9 illegal code visible", int'(busy_o), 1);
        @(negedge clk_a);
        chk(busy_o == 1'b0, "R9 recovered busy", int'(busy_o), 0);
        chk(req_o == 1'b0, "R9 recovered req", int'(req_o), 0);
        send(acc);
        chk(acc, "R9 usable after recovery", int'(acc), 1);
        wait_idle();
        settle(20);
        chk(rx_count == accepted, "R9 strobe after recovery", rx_count, accepted);

        finish_run();
    end

endmodule